// File: doc/BRIEF.md
# Debug Breakpoint Response Controller

This block sits between the breakpoint comparators of a processor core and the core's control logic. Each cycle it receives hit pulses: a precise program-counter match, and imprecise address/data matches tagged as first or second level. A two-bit response field in a small trigger definition register picks what a hit does. One value halts the core. Another raises a debug interrupt that outranks every ordinary interrupt level, including the non-maskable one.

A debug interrupt is taken only at an instruction sample point, which the core signals once per instruction. A program-counter hit that coincides with the sample point of its instruction is taken at that same sample point, so the instruction never executes. Address/data hits are registered first and wait for a later sample point. Taking the interrupt enters emulator mode. The block then drives a debug-entry status code for a fixed window, supplies the debug exception vector, and blocks all other interrupts until the core reports a return from exception.

The block also keeps a breakpoint status field. It records the highest breakpoint level seen. Reads of the status register and writes to the trigger definition register clear it under set rules.

Top module: `dbg_brk_resp`

## Requirements
- R1: After reset, `pst` is 0x0, `halt_req`, `dbg_irq` and `emu_mode` are 0, and both registers read as 0.
- R2: With response field (trigger definition bits [1:0]) equal to 01, a qualified hit sets `halt_req` on the next cycle, and `pst` reads 0xF while it is set. It stays set until the next write to the trigger definition register.
- R3: With response field 10, an address/data hit raises `dbg_irq` on the next cycle. It stays raised until a cycle with `sample_pt` high, and `emu_mode` is set after that cycle.
- R4: With response field 10 and the PC enable (bit 3) set, a PC hit in the same cycle as `sample_pt` sets `emu_mode` on the next cycle, and `dbg_irq` is never raised. An address/data hit in a `sample_pt` cycle is not taken at that sample point.
- R5: On entry to emulator mode, `pst` reads 0xD and `vec_num` reads 12 for exactly 4 cycles. After that, `pst` is 0x0 and `vec_num` is 0.
- R6: `irq_fwd` passes `irq_in` through, except that it is 0 while `emu_mode` or `dbg_irq` is high.
- R7: A hit with response 10 while `emu_mode` is high keeps `dbg_irq` low, and `dbg_irq` rises on the cycle after emulator mode exits.
- R8: `rte_done` while in emulator mode clears `emu_mode` on the next cycle. If the entry was caused by a PC hit, the PC enable is still set, the response is still 10, and no trigger definition write happened since entry, then `dbg_irq` is raised again at the same time.
- R9: Status (status register bits [1:0]) takes 1 on a first-level hit and 2 on a second-level hit (`ad_hit` with `ad_lvl2`). A later first-level hit does not lower a 2.
- R10: A status register read (`reg_rd` with `reg_sel`=1) clears the status when it is 2, or when it is 1 and the second-level enable (trigger definition bit 2) is 0. Otherwise the read leaves it unchanged.
- R11: Any write to the trigger definition register (`reg_wr` with `reg_sel`=0) clears the status field.
- R12: Response values 00 and 11 raise neither `halt_req` nor `dbg_irq`, but hits still update the status field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_hit | input | 1 | Program-counter breakpoint match (first level) |
| ad_hit | input | 1 | Address/data breakpoint match |
| ad_lvl2 | input | 1 | Marks `ad_hit` as second level |
| sample_pt | input | 1 | Instruction interrupt sample point |
| rte_done | input | 1 | Return from exception completed |
| irq_in | input | 3 | Ordinary interrupt level request |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_sel | input | 1 | 0 = trigger definition, 1 = status |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the selected register |
| halt_req | output | 1 | Core halt request |
| dbg_irq | output | 1 | Pending debug interrupt |
| irq_fwd | output | 3 | Interrupt level passed to the core |
| pst | output | 4 | Processor status code |
| vec_num | output | 8 | Exception vector number |
| emu_mode | output | 1 | Emulator mode flag |

## Verification
The assertions check on every cycle that a sample point with a raised debug interrupt enters emulator mode, and that a return from exception leaves it. They also check that ordinary interrupts stay blocked in emulator mode, that entry shows the debug code and vector, that a halt-response hit raises the halt request, and that a definition write clears the status. Only the directed scenarios can show the behaviours that need history: the four-cycle status window, the re-raise after return when a PC breakpoint is left armed, the deferral of hits that arrive inside emulator mode, the precise versus imprecise timing at a sample point, and the level-dependent clear-on-read rules.

// File: rtl/dbg_brk_resp.sv
module dbg_brk_resp #(
  parameter int DW       = 8,
  parameter int VEC_DBG  = 12,
  parameter int PST_HOLD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pc_hit,
  input  logic          ad_hit,
  input  logic          ad_lvl2,
  input  logic          sample_pt,
  input  logic          rte_done,
  input  logic [2:0]    irq_in,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          halt_req,
  output logic          dbg_irq,
  output logic [2:0]    irq_fwd,
  output logic [3:0]    pst,
  output logic [7:0]    vec_num,
  output logic          emu_mode
);

  localparam int CW = $clog2(PST_HOLD + 1);
  localparam logic [3:0] PST_RUN  = 4'h0;
  localparam logic [3:0] PST_DBG  = 4'hD;
  localparam logic [3:0] PST_HALT = 4'hF;
  localparam logic [1:0] ST_L1 = 2'd1;
  localparam logic [1:0] ST_L2 = 2'd2;

  logic [3:0]    tdr_q;
  logic [1:0]    bstat_q;
  logic          halt_q, pend_q, pend_pc_q, emu_q, from_pc_q, dirty_q;
  logic [CW-1:0] cnt_q;

  wire [1:0] resp    = tdr_q[1:0];
  wire       lvl2_en = tdr_q[2];
  wire       pc_en   = tdr_q[3];

  wire resp_halt = (resp == 2'b01);
  wire resp_irq  = (resp == 2'b10);
  wire pc_ev     = pc_hit & pc_en;
  wire any_ev    = pc_ev | ad_hit;
  wire [1:0] ev_lvl = (ad_hit & ad_lvl2) ? ST_L2 : ST_L1;

  wire tdr_wr = reg_wr & ~reg_sel;
  wire st_rd  = reg_rd & reg_sel;

  wire pc_now = pc_ev & resp_irq & sample_pt & ~emu_q;
  wire take   = sample_pt & ~emu_q & (pend_q | pc_now);
  wire rearm  = emu_q & rte_done & from_pc_q & pc_en & resp_irq & ~dirty_q;
  wire rd_clr = (bstat_q == ST_L2) | ((bstat_q == ST_L1) & ~lvl2_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tdr_q <= '0;
    else if (tdr_wr) tdr_q <= reg_wdata[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bstat_q <= '0;
    else if (any_ev) bstat_q <= (bstat_q == ST_L2) ? ST_L2 : ev_lvl;
    else if (tdr_wr) bstat_q <= '0;
    else if (st_rd && rd_clr) bstat_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else if (any_ev && resp_halt) halt_q <= 1'b1;
    else if (tdr_wr) halt_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_pc_q <= 1'b0;
    end else if (take) begin
      pend_q    <= ad_hit & resp_irq;
      pend_pc_q <= 1'b0;
    end else if ((any_ev && resp_irq) || rearm) begin
      pend_q    <= 1'b1;
      pend_pc_q <= pend_pc_q | rearm | (pc_ev & resp_irq);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emu_q     <= 1'b0;
      from_pc_q <= 1'b0;
      dirty_q   <= 1'b0;
    end else if (take) begin
      emu_q     <= 1'b1;
      from_pc_q <= pc_now | pend_pc_q;
      dirty_q   <= 1'b0;
    end else begin
      if (rte_done) emu_q <= 1'b0;
      if (tdr_wr) dirty_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (take) cnt_q <= CW'(PST_HOLD);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign halt_req  = halt_q;
  assign emu_mode  = emu_q;
  assign dbg_irq   = pend_q & ~emu_q;
  assign irq_fwd   = (emu_q | dbg_irq) ? 3'd0 : irq_in;
  assign pst       = halt_q ? PST_HALT : ((cnt_q != '0) ? PST_DBG : PST_RUN);
  assign vec_num   = (cnt_q != '0) ? 8'(VEC_DBG) : 8'd0;
  assign reg_rdata = reg_sel ? {{(DW-2){1'b0}}, bstat_q} : {{(DW-4){1'b0}}, tdr_q};

  a_r2_halt_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_halt && any_ev) |=> (halt_req && pst == PST_HALT));

  a_r3_sample_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pt && dbg_irq) |=> emu_mode);

  a_r5_entry_code: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(emu_mode) && !halt_req) |-> (pst == PST_DBG && vec_num == 8'(VEC_DBG)));

  a_r6_emu_masks: assert property (@(posedge clk) disable iff (!rst_n)
    emu_mode |-> (irq_fwd == 3'd0 && !dbg_irq));

  a_r8_rte_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_mode && rte_done) |=> !emu_mode);

  a_r11_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tdr_wr && !pc_hit && !ad_hit) |=> (bstat_q == 2'd0));

endmodule

// File: tb/dbg_brk_resp_bench.sv
`timescale 1ns/1ps
module dbg_brk_resp_bench;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pc_hit = 0, ad_hit = 0, ad_lvl2 = 0, sample_pt = 0, rte_done = 0;
  logic [2:0] irq_in = 0;
  logic reg_wr = 0, reg_rd = 0, reg_sel = 0;
  logic [DW-1:0] reg_wdata = 0, reg_rdata;
  logic halt_req, dbg_irq, emu_mode;
  logic [2:0] irq_fwd;
  logic [3:0] pst;
  logic [7:0] vec_num;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_brk_resp u_dbg_brk_resp (
    .clk(clk), .rst_n(rst_n), .pc_hit(pc_hit), .ad_hit(ad_hit), .ad_lvl2(ad_lvl2),
    .sample_pt(sample_pt), .rte_done(rte_done), .irq_in(irq_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .halt_req(halt_req), .dbg_irq(dbg_irq), .irq_fwd(irq_fwd),
    .pst(pst), .vec_num(vec_num), .emu_mode(emu_mode));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr_tdr(input logic [DW-1:0] v);
    reg_wr = 1; reg_sel = 0; reg_wdata = v; tick(); reg_wr = 0;
  endtask

  task automatic status(output logic [1:0] s);
    reg_sel = 1; #1; s = reg_rdata[1:0]; reg_sel = 0; #1;
  endtask

  task automatic rd_status();
    reg_sel = 1; reg_rd = 1; tick(); reg_rd = 0; reg_sel = 0;
  endtask

  task automatic hit_ad(input logic l2, input logic sp);
    ad_hit = 1; ad_lvl2 = l2; sample_pt = sp; tick(); ad_hit = 0; ad_lvl2 = 0; sample_pt = 0;
  endtask

  task automatic pulse_sp();
    sample_pt = 1; tick(); sample_pt = 0;
  endtask

  task automatic pulse_rte();
    rte_done = 1; tick(); rte_done = 0;
  endtask

  task automatic t_reset();
    chk("R1 pst", pst, 0);
    chk("R1 halt", halt_req, 0);
    chk("R1 irq", dbg_irq, 0);
    chk("R1 emu", emu_mode, 0);
    reg_sel = 0; #1; chk("R1 tdr", reg_rdata, 0);
    reg_sel = 1; #1; chk("R1 status", reg_rdata, 0);
    reg_sel = 0;
  endtask

  task automatic t_halt();
    logic [1:0] s;
    wr_tdr(8'h01);
    hit_ad(0, 0);
    chk("R2 halt set", halt_req, 1);
    chk("R2 pst F", pst, 4'hF);
    tick();
    chk("R2 halt held", halt_req, 1);
    status(s); chk("R9 level1 code", s, 1);
    wr_tdr(8'h02);
    chk("R2 halt cleared by write", halt_req, 0);
    chk("R2 pst back", pst, 0);
    status(s); chk("R11 write clears status", s, 0);
  endtask

  task automatic t_irq_ad();
    irq_in = 3'd7;
    hit_ad(0, 0);
    chk("R3 irq raised", dbg_irq, 1);
    chk("R3 not yet emu", emu_mode, 0);
    chk("R6 debug outranks level 7", irq_fwd, 0);
    tick();
    chk("R3 irq pending", dbg_irq, 1);
    pulse_sp();
    chk("R3 emu entered", emu_mode, 1);
    chk("R3 irq dropped", dbg_irq, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R5 pst D", pst, 4'hD);
      chk("R5 vector 12", vec_num, 12);
      irq_in = 3'd5;
      chk("R6 masked in emu", irq_fwd, 0);
      tick();
    end
    chk("R5 pst normal", pst, 0);
    chk("R5 vector off", vec_num, 0);
    pulse_rte();
    chk("R8 emu cleared", emu_mode, 0);
    chk("R8 no rearm for address hit", dbg_irq, 0);
    chk("R6 pass-through", irq_fwd, 5);
    irq_in = 0;
  endtask

  task automatic t_imprecise();
    hit_ad(0, 1);
    chk("R4 address hit not taken at its sample point", emu_mode, 0);
    chk("R4 address hit pending", dbg_irq, 1);
    pulse_sp();
    chk("R4 taken at later sample point", emu_mode, 1);
    repeat (5) tick();
    pulse_rte();
    chk("R8 exit", emu_mode, 0);
  endtask

  task automatic t_pc();
    wr_tdr(8'h0A);
    pc_hit = 1; sample_pt = 1;
    #1; chk("R4 no interrupt request before take", dbg_irq, 0);
    tick(); pc_hit = 0; sample_pt = 0;
    chk("R4 precise entry", emu_mode, 1);
    repeat (5) tick();
    pulse_rte();
    chk("R8 emu cleared", emu_mode, 0);
    chk("R8 pc rearm", dbg_irq, 1);
    pulse_sp();
    chk("R8 re-entry", emu_mode, 1);
    wr_tdr(8'h02);
    repeat (4) tick();
    pulse_rte();
    chk("R8 exit after rewrite", emu_mode, 0);
    chk("R8 no rearm after rewrite", dbg_irq, 0);
  endtask

  task automatic t_latch();
    hit_ad(0, 0);
    pulse_sp();
    chk("R7 in emu", emu_mode, 1);
    hit_ad(0, 0);
    chk("R7 hit held back", dbg_irq, 0);
    repeat (4) tick();
    chk("R7 still held", dbg_irq, 0);
    pulse_rte();
    chk("R7 presented after exit", dbg_irq, 1);
    pulse_sp();
    repeat (5) tick();
    pulse_rte();
    chk("R7 drained", dbg_irq, 0);
  endtask

  task automatic t_status();
    logic [1:0] s;
    wr_tdr(8'h00);
    hit_ad(0, 0);
    chk("R12 resp 00 no halt", halt_req, 0);
    chk("R12 resp 00 no irq", dbg_irq, 0);
    status(s); chk("R12 status updated", s, 1);
    rd_status();
    status(s); chk("R10 L1 read clears without L2 enable", s, 0);
    wr_tdr(8'h04);
    hit_ad(0, 0);
    rd_status();
    status(s); chk("R10 L1 read kept with L2 enable", s, 1);
    hit_ad(1, 0);
    status(s); chk("R9 level2 code", s, 2);
    hit_ad(0, 0);
    status(s); chk("R9 level2 sticky", s, 2);
    rd_status();
    status(s); chk("R10 L2 read clears", s, 0);
    wr_tdr(8'h07);
    hit_ad(0, 0);
    chk("R12 resp 11 no halt", halt_req, 0);
    chk("R12 resp 11 no irq", dbg_irq, 0);
    status(s); chk("R12 resp 11 status", s, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tick();
    t_reset();
    t_halt();
    t_irq_ad();
    t_imprecise();
    t_pc();
    t_latch();
    t_status();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule